// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with an 8-bit up-counter. A 12-bit prescaler divides the peripheral clock, and one of eight taps of that prescaler drives the counter. Software reaches the block through a simple 16-bit write port and a read port. A write changes a register only when it is a word-sized transfer and its upper byte holds the key for the target register. The lower byte of such a write becomes the register data. Any other write is rejected and leaves every register as it was. The block flags a rejected write with a one-cycle error strobe.

When the counter wraps from 0xFF to 0x00, the block sets a sticky overflow flag in its control/status register. It also raises a one-cycle overflow pulse for the surrounding reset or interrupt logic. A timer-enable bit in the same register starts and stops counting. Stopping the timer also clears the prescaler. The clock-select field can only change while the timer is stopped, so a running count cannot be corrupted.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter is 0x00, and the control/status register is 0x00 (stopped, divide-by-1, flag clear). ovfPulse and wrErr are low.
- R2: A counter write (wrSel=0) is accepted only when wrSize=01 (word) and wrData[15:8]=0x5A. The counter then takes wrData[7:0] at the next clock edge.
- R3: A control/status write (wrSel=1) is accepted only when wrSize=01 and wrData[15:8]=0xA5. The register layout is: bit 7 overflow flag, bit 6 run enable, bits 2:0 clock select, and bits 5:3 read as 0.
- R4: Writes with wrSize=00 (byte) or wrSize=10/11 (longword) change no register. wrErr is high for exactly the one cycle after such a write.
- R5: A word write whose upper byte is not the key of the selected register changes no register. wrErr is high in the cycle after that write.
- R6: While running, the counter advances once every N clocks. N is 1, 4, 16, 32, 64, 256, 1024 or 4096 for clock-select values 0 to 7. The first advance comes N clocks after the run bit becomes set.
- R7: An accepted control/status write made while the run bit is already 1 leaves the clock-select field unchanged. The same write made while the timer is stopped loads the new value.
- R8: When the counter advances from 0xFF to 0x00, the overflow flag is set and ovfPulse is high for exactly that one cycle.
- R9: An accepted control/status write with bit 7 = 0 clears the overflow flag, and writing bit 7 = 1 never sets it. An overflow in the same cycle as a clearing write leaves the flag set.
- R10: While the run bit is 0, the counter holds its value and the prescaler is held at zero.
- R11: When an accepted counter write and a counter advance fall in the same cycle, the written value is loaded and no increment or overflow occurs.
- R12: rdData returns the counter (rdSel=0) or the control/status register (rdSel=1) in bits 7:0, with bits 15:8 at zero. No key is needed to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request, one cycle per transfer |
| wrSize | input | 2 | Transfer size: 00 byte, 01 word, 10/11 longword |
| wrSel | input | 1 | Target register: 0 counter, 1 control/status |
| wrData | input | 16 | Key in the upper byte, data in the lower byte |
| rdSel | input | 1 | Read select: 0 counter, 1 control/status |
| rdData | output | 16 | Read data, upper byte zero |
| ovfPulse | output | 1 | One-cycle pulse on counter wrap |
| wrErr | output | 1 | One-cycle strobe after a rejected write |

## Verification
Some rules are checked by the in-line assertions on every cycle. These are: a wrong size or wrong key raises the error strobe and causes no load; a stopped timer holds its count; a running timer keeps its clock select; and the overflow pulse lasts one cycle and coincides with the flag. The exact divider periods, when the first advance arrives after enabling, write-versus-advance priority, and flag set winning over a clearing write can only be shown by the bench scenarios. In those scenarios a behavioural model is compared with the read port and both strobes on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LONG_ALT = 2'b11
  } xferSize_e;

  typedef struct packed {
    logic       cntLoad;
    logic       csrLoad;
    logic [7:0] data;
  } wrStrobe_t;

  localparam int CSR_FLAG_BIT = 7;
  localparam int CSR_RUN_BIT  = 6;
  localparam int SEL_W        = 3;
  localparam int SEL_COUNT    = 1 << SEL_W;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int         DATA_W  = 16,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CSR_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSize,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobe_t         strobe,
  output logic              wrErr
);

  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] keyByte;
  logic [BYTE_W-1:0] dataByte;
  logic              isWord;
  logic              keyOk;
  logic              accept;

  assign keyByte  = wrData[DATA_W-1:BYTE_W];
  assign dataByte = wrData[BYTE_W-1:0];
  assign isWord   = (xferSize_e'(wrSize) == SZ_WORD);
  assign keyOk    = wrSel ? (keyByte == CSR_KEY) : (keyByte == CNT_KEY);
  assign accept   = wrEn && isWord && keyOk;

  always_comb begin
    strobe         = '0;
    strobe.cntLoad = accept && !wrSel;
    strobe.csrLoad = accept && wrSel;
    strobe.data    = dataByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= wrEn && !accept;
  end

  // R4
  size_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize != 2'b01) |-> !(strobe.cntLoad || strobe.csrLoad));

  // R4
  size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize != 2'b01) |=> wrErr);

  // R5
  key_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && wrData[15:8] != 8'h5A) |-> (!strobe.cntLoad ##1 wrErr));

  // R2
  load_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntLoad && strobe.csrLoad));

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic [7:0]       csrQ,
  output logic             ovfPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRE_W-1:0] preQ;
  logic [SEL_W-1:0] selQ;
  logic             runQ;
  logic             flagQ;
  logic             tick;
  logic             wrap;
  logic [PRE_W-1:0] tapMask [SEL_COUNT];

  function automatic int selShift(input int s);
    case (s)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 5;
      4: return 6;
      5: return 8;
      6: return 10;
      default: return 12;
    endcase
  endfunction

  for (genvar g = 0; g < SEL_COUNT; g++) begin : g_tap
    localparam int SH = (selShift(g) > PRE_W) ? PRE_W : selShift(g);
    assign tapMask[g] = PRE_W'((64'd1 << SH) - 64'd1);
  end

  assign tick = runQ && ((preQ & tapMask[selQ]) == tapMask[selQ]);
  assign wrap = tick && !strobe.cntLoad && (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN)     preQ <= '0;
    else if (runQ) preQ <= preQ + 1'b1;
    else           preQ <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.cntLoad) cntQ <= strobe.data[CNT_W-1:0];
    else if (tick)           cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      selQ     <= '0;
      flagQ    <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= wrap;
      if (strobe.csrLoad) begin
        runQ <= strobe.data[CSR_RUN_BIT];
        if (!runQ) selQ <= strobe.data[SEL_W-1:0];
      end
      if (wrap)                                            flagQ <= 1'b1;
      else if (strobe.csrLoad && !strobe.data[CSR_FLAG_BIT]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    csrQ               = '0;
    csrQ[CSR_FLAG_BIT] = flagQ;
    csrQ[CSR_RUN_BIT]  = runQ;
    csrQ[SEL_W-1:0]    = selQ;
  end

  // R7
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> selQ == $past(selQ));

  // R10
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !strobe.cntLoad) |=> (cntQ == $past(cntQ)) && (preQ == '0));

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (flagQ && cntQ == '0));

  // R8
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> (cntQ == $past(strobe.data[CNT_W-1:0])) && !ovfPulse);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSize,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              ovfPulse,
  output logic              wrErr
);

  localparam int BYTE_W = DATA_W / 2;

  wrStrobe_t        strobe;
  logic [CNT_W-1:0] cntQ;
  logic [7:0]       csrQ;
  logic [BYTE_W-1:0] rdByte;

  wdt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSize (wrSize),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe),
    .wrErr  (wrErr)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntQ     (cntQ),
    .csrQ     (csrQ),
    .ovfPulse (ovfPulse)
  );

  assign rdByte = rdSel ? BYTE_W'(csrQ) : BYTE_W'(cntQ);
  assign rdData = {{(DATA_W-BYTE_W){1'b0}}, rdByte};

  // R12
  rd_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:BYTE_W] == '0);

endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSize = 2'b01;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [15:0] rdData;
  logic        ovfPulse;
  logic        wrErr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  int mCnt, mPre, mSel;
  bit mRun, mFlag, mPulse, mErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSize(wrSize), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .ovfPulse(ovfPulse), .wrErr(wrErr)
  );

  function automatic int divOf(input int s);
    int d[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return d[s];
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mSel = 0; mRun = 0; mFlag = 0; mPulse = 0; mErr = 0;
    end else begin
      bit cntW, csrW, tick, wrapped;
      int lo, hi;
      lo = wrData[7:0]; hi = wrData[15:8];
      cntW = wrEn && wrSize == 2'b01 && !wrSel && hi == 'h5A;
      csrW = wrEn && wrSize == 2'b01 && wrSel && hi == 'hA5;
      mErr = wrEn && !cntW && !csrW;
      tick = mRun && ((mPre % divOf(mSel)) == divOf(mSel) - 1);
      wrapped = 0;
      if (cntW) mCnt = lo;
      else if (tick) begin
        if (mCnt == 255) begin mCnt = 0; wrapped = 1; end
        else mCnt = mCnt + 1;
      end
      mPulse = wrapped;
      if (wrapped) mFlag = 1;
      else if (csrW && lo[7] == 0) mFlag = 0;
      mPre = mRun ? (mPre + 1) % 4096 : 0;
      if (csrW) begin
        if (!mRun) mSel = lo % 8;
        mRun = lo[6];
      end
    end
  end

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    int expRd;
    expRd = rdSel ? ((mFlag << 7) | (mRun << 6) | mSel) : mCnt;
    check(rdData[7:0], expRd, "read data");
    check(rdData[15:8], 0, "R12 upper byte");
    check(ovfPulse, mPulse, "overflow pulse");
    check(wrErr, mErr, "write error");
  endtask

  // drive one cycle: inputs set after a negedge, compare at the next negedge
  task automatic cyc(input bit we, input logic [1:0] sz, input bit sel, input logic [15:0] d);
    wrEn = we; wrSize = sz; wrSel = sel; wrData = d;
    rdSel = ~rdSel;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'b01, 0, 16'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values on both registers
    curReq = "R1";
    rdSel = 1'b1;
    cyc(0, 2'b01, 0, 0);
    idle(2);

    // R2: keyed counter write
    curReq = "R2";
    cyc(1, 2'b01, 0, 16'h5A37);
    idle(2);

    // R5: wrong keys to both registers
    curReq = "R5";
    cyc(1, 2'b01, 0, 16'h5B11);
    cyc(1, 2'b01, 0, 16'hA522);
    cyc(1, 2'b01, 1, 16'h5A47);
    idle(2);

    // R4: byte and longword sizes with correct keys
    curReq = "R4";
    cyc(1, 2'b00, 0, 16'h5A99);
    cyc(1, 2'b10, 1, 16'hA547);
    cyc(1, 2'b11, 0, 16'h5A01);
    idle(2);

    // R3: control/status write while stopped, then start at divide-by-16
    curReq = "R3";
    cyc(1, 2'b01, 1, 16'hA502);
    idle(2);
    curReq = "R6";
    cyc(1, 2'b01, 1, 16'hA542);
    idle(100);

    // R7: select change ignored while running
    curReq = "R7";
    cyc(1, 2'b01, 1, 16'hA545);
    idle(60);

    // R10: stop and hold
    curReq = "R10";
    cyc(1, 2'b01, 1, 16'hA505);
    idle(50);
    curReq = "R7";
    cyc(1, 2'b01, 1, 16'hA500);
    idle(3);

    // R8: overflow at divide-by-1
    curReq = "R8";
    cyc(1, 2'b01, 0, 16'h5AFC);
    cyc(1, 2'b01, 1, 16'hA540);
    idle(10);

    // R9: clear, and writing 1 does not set
    curReq = "R9";
    cyc(1, 2'b01, 1, 16'hA540);
    idle(2);
    cyc(1, 2'b01, 1, 16'hA5C0);
    idle(2);

    // R11: counter write while advancing every cycle
    curReq = "R11";
    cyc(1, 2'b01, 0, 16'h5A10);
    idle(3);
    cyc(1, 2'b01, 0, 16'h5AFF);
    cyc(1, 2'b01, 0, 16'h5AFF);
    idle(3);

    // R9: overflow coinciding with a clearing write keeps the flag
    curReq = "R9";
    cyc(1, 2'b01, 0, 16'h5AFF);
    cyc(1, 2'b01, 1, 16'hA540);
    idle(3);

    // R6: every divider setting
    curReq = "R6";
    for (int s = 0; s < 8; s++) begin
      cyc(1, 2'b01, 1, 16'hA500);
      cyc(1, 2'b01, 0, 16'h5A00);
      cyc(1, 2'b01, 1, 16'hA540 | 16'(s));
      idle(3 * divOf(s) + 5);
    end

    // R12: final explicit read of both registers
    curReq = "R12";
    cyc(1, 2'b01, 1, 16'hA500);
    idle(4);
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule